// File: doc/BRIEF.md
# Message-Signalled Interrupt Concentrator

This block gathers eleven level-sensitive interrupt lines from peripherals and reports them upstream as one interrupt. The interrupt is not a wire. It is a single write transaction that carries a programmed data word to a programmed address. Each line passes through a synchroniser. A low-to-high transition on a line that is enabled in the mask latches a pending bit, and a newly latched pending bit triggers one message write on a valid/ready output.

Software reaches four registers and the target word through a simple register port. The mask register enables lines one bit each. The live-level register shows the synchronised state of every line, masked or not, so software can catch a line that was already high when it was unmasked and handle it as level-triggered. Two pending views clear on read:
- The primary view returns and clears only the architected subset of bits.
- The secondary view returns and clears all eleven bits.

Top module: `msi_irq_concentrator`

## Requirements
- R1: After reset, every register reads zero: target word (0x004), primary pending (0x00C), mask (0x018), secondary pending (0x01C) and level (0x028). `msg_valid` is low.
- R2: A low-to-high transition on `irq_lines[i]` while mask bit i is 1 sets pending bit i. Bit i has the same position in the mask, pending and level registers.
- R3: A transition on a masked line sets no pending bit. A line that is already high when its mask bit is set produces no pending bit and no message.
- R4: A read of 0x00C returns the pending bits ANDed with 0x5FF, and clears exactly those bits. Pending bit 9 is neither returned nor cleared.
- R5: A read of 0x01C returns all eleven pending bits and clears them. The level register is not changed by it.
- R6: A read of 0x028 returns the synchronised state of all eleven lines, whatever the mask holds.
- R7: When a new pending bit is set and the target word has been written, `msg_valid` rises. `msg_addr` is the target word with its low 5 bits cleared. `msg_data` is the target word's low 5 bits, zero-extended.
- R8: While `msg_valid` is high and `msg_ready` is low, `msg_addr` and `msg_data` hold. Events that arrive while a message is waiting merge into it, so a single handshake completes them all.
- R9: No message is raised before the target word has been written once since reset.
- R10: A line that rises before clock edge k sets its pending bit at edge k+2, when `msg_valid` also rises. Neither happens at edge k+1.
- R11: A rising edge that is captured on the same clock edge as a clearing read stays pending. The read returns the value from before that edge.
- R12: The mask (0x018) reads back its written low 11 bits. The target word (0x004) reads back all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | 11 | Asynchronous interrupt lines, active high |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe; data appears the next cycle |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data |
| msg_valid | output | 1 | Message write request |
| msg_ready | input | 1 | Upstream accepts the message |
| msg_addr | output | 32 | Message target address |
| msg_data | output | 32 | Message data word |

## Verification
The bench builds the block with its defaults:
- eleven lines;
- a primary-view subset of 0x5FF;
- five data bits in the target word;
- a two-stage synchroniser.

Because bit 9 lies outside the primary subset, a pending bit 9 can be seen surviving a primary read and then being consumed by a secondary read. The two-stage depth fixes the two-edge latency that the bench uses to line a captured edge up with a clearing read.

// File: rtl/irqc_pkg.sv
// Shared register offsets and decode for the interrupt concentrator.
// Assumes byte offsets on a 12-bit register port.
package irqc_pkg;
    localparam int unsigned CFG_AW = 12;
    localparam int unsigned CFG_DW = 32;

    localparam logic [CFG_AW-1:0] OFS_TARGET = 12'h004;
    localparam logic [CFG_AW-1:0] OFS_PEND_A = 12'h00C;
    localparam logic [CFG_AW-1:0] OFS_MASK   = 12'h018;
    localparam logic [CFG_AW-1:0] OFS_PEND_B = 12'h01C;
    localparam logic [CFG_AW-1:0] OFS_LEVEL  = 12'h028;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_TARGET,
        SEL_PEND_A,
        SEL_MASK,
        SEL_PEND_B,
        SEL_LEVEL
    } reg_sel_e;

    // Map a byte offset to a register select.
    function automatic reg_sel_e decode_ofs(input logic [CFG_AW-1:0] ofs);
        case (ofs)
            OFS_TARGET: return SEL_TARGET;
            OFS_PEND_A: return SEL_PEND_A;
            OFS_MASK:   return SEL_MASK;
            OFS_PEND_B: return SEL_PEND_B;
            OFS_LEVEL:  return SEL_LEVEL;
            default:    return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/irqc_sync.sv
// Synchroniser and rising-edge detector for a vector of asynchronous lines.
// Assumes each line is held long enough to be seen by the first stage.
module irqc_sync #(
    parameter int unsigned N_IN   = 11,
    parameter int unsigned STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] lines_async,
    output logic [N_IN-1:0] level,
    output logic [N_IN-1:0] rise
);
    logic [N_IN-1:0] chain [STAGES];
    logic [N_IN-1:0] prev_q;

    // Shift the raw lines through the synchroniser stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= lines_async;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    // Remember the last synchronised value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign rise  = level & ~prev_q;
endmodule

// File: rtl/irqc_pending.sv
// Pending-bit store: sets on enabled rising edges, clears on read strobes.
// Assumes a set and a clear in the same cycle leave the bit set.
module irqc_pending #(
    parameter int unsigned N_IN = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] rise,
    input  logic [N_IN-1:0] enable,
    input  logic [N_IN-1:0] clr_vec,
    output logic [N_IN-1:0] pending,
    output logic [N_IN-1:0] set_vec,
    output logic            new_evt
);
    logic [N_IN-1:0] pending_q;

    assign set_vec = rise & enable;
    assign new_evt = |set_vec;
    assign pending = pending_q;

    // Update pending bits; new edges win over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pending_q <= '0;
        else        pending_q <= (pending_q & ~clr_vec) | set_vec;
    end

    // R3: a bit may only become pending if its line was enabled.
    assert_masked_no_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pending_q & ~$past(pending_q) & ~$past(enable)) == '0));
endmodule

// File: rtl/irqc_msg.sv
// Message launcher: raises one write request per batch of new events.
// Assumes the target word is stable once armed; it is latched at launch.
module irqc_msg #(
    parameter int unsigned DATA_W = 5,
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              armed,
    input  logic              new_evt,
    input  logic [WORD_W-1:0] target,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [WORD_W-1:0] msg_addr,
    output logic [WORD_W-1:0] msg_data
);
    logic              valid_q;
    logic [WORD_W-1:0] word_q;
    logic              launch;

    assign launch = new_evt && armed && (!valid_q || msg_ready);

    // Track the outstanding request and latch the target word at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            word_q  <= '0;
        end else if (launch) begin
            valid_q <= 1'b1;
            word_q  <= target;
        end else if (valid_q && msg_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign msg_valid = valid_q;
    assign msg_addr  = {word_q[WORD_W-1:DATA_W], {DATA_W{1'b0}}};
    assign msg_data  = {{(WORD_W-DATA_W){1'b0}}, word_q[DATA_W-1:0]};

    // R8: a waiting message holds its contents.
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    // R9: no request while unarmed.
    assert_unarmed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !msg_valid);

    // R7: a new event with nothing outstanding raises a request.
    assert_launch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (new_evt && armed && !msg_valid) |=> msg_valid);
endmodule

// File: rtl/msi_irq_concentrator.sv
// Top of the interrupt concentrator: register port, mask, target word and
// the composition of synchroniser, pending store and message launcher.
// Assumes one register access per cycle; a write takes priority over a read.
module msi_irq_concentrator
    import irqc_pkg::*;
#(
    parameter int unsigned     N_IN         = 11,
    parameter logic [N_IN-1:0] PRIMARY_MASK = 11'h5FF,
    parameter int unsigned     DATA_W       = 5,
    parameter int unsigned     SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   irq_lines,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic [CFG_DW-1:0] cfg_rdata,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [CFG_DW-1:0] msg_addr,
    output logic [CFG_DW-1:0] msg_data
);
    localparam int unsigned PAD_W = CFG_DW - N_IN;

    reg_sel_e          sel;
    logic              rd_en, wr_en;
    logic              rd_pend_a, rd_pend_b;
    logic [N_IN-1:0]   level, rise, pending, set_vec, clr_vec;
    logic              new_evt;
    logic [N_IN-1:0]   mask_q;
    logic [CFG_DW-1:0] target_q;
    logic              armed_q;
    logic [CFG_DW-1:0] rdata_q;

    assign sel       = decode_ofs(cfg_addr);
    assign wr_en     = cfg_wr;
    assign rd_en     = cfg_rd && !cfg_wr;
    assign rd_pend_a = rd_en && (sel == SEL_PEND_A);
    assign rd_pend_b = rd_en && (sel == SEL_PEND_B);

    // Build the clear vector from clearing reads.
    always_comb begin
        clr_vec = '0;
        if (rd_pend_a) clr_vec = PRIMARY_MASK;
        if (rd_pend_b) clr_vec = '1;
    end

    irqc_sync #(.N_IN(N_IN), .STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .lines_async(irq_lines),
        .level(level), .rise(rise)
    );

    irqc_pending #(.N_IN(N_IN)) i_pending (
        .clk(clk), .rst_n(rst_n), .rise(rise), .enable(mask_q),
        .clr_vec(clr_vec), .pending(pending), .set_vec(set_vec),
        .new_evt(new_evt)
    );

    irqc_msg #(.DATA_W(DATA_W), .WORD_W(CFG_DW)) i_msg (
        .clk(clk), .rst_n(rst_n), .armed(armed_q), .new_evt(new_evt),
        .target(target_q), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    // Register writes: mask, target word and the arm flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '0;
            target_q <= '0;
            armed_q  <= 1'b0;
        end else if (wr_en) begin
            if (sel == SEL_MASK) mask_q <= cfg_wdata[N_IN-1:0];
            if (sel == SEL_TARGET) begin
                target_q <= cfg_wdata;
                armed_q  <= 1'b1;
            end
        end
    end

    // Registered read data from the state before this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            case (sel)
                SEL_TARGET: rdata_q <= target_q;
                SEL_PEND_A: rdata_q <= {{PAD_W{1'b0}}, pending & PRIMARY_MASK};
                SEL_MASK:   rdata_q <= {{PAD_W{1'b0}}, mask_q};
                SEL_PEND_B: rdata_q <= {{PAD_W{1'b0}}, pending};
                SEL_LEVEL:  rdata_q <= {{PAD_W{1'b0}}, level};
                default:    rdata_q <= '0;
            endcase
        end
    end

    assign cfg_rdata = rdata_q;

    // R4: after a primary read, only freshly set bits of the subset remain.
    assert_pend_a_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pend_a |=> ((pending & PRIMARY_MASK & ~$past(set_vec)) == '0));

    // R5: after a secondary read, only freshly set bits remain.
    assert_pend_b_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pend_b |=> ((pending & ~$past(set_vec)) == '0));
endmodule

// File: tb/test_msi_irq_concentrator.sv
`timescale 1ns/1ps
module test_msi_irq_concentrator;
    localparam int N = 11;
    localparam logic [11:0] A_TGT = 12'h004, A_PA = 12'h00C, A_MSK = 12'h018,
                            A_PB = 12'h01C, A_LVL = 12'h028;
    // {mask, line pattern, expected secondary pending}
    localparam logic [32:0] VEC [6] = '{
        {11'h7FF, 11'h001, 11'h001},
        {11'h7FF, 11'h040, 11'h040},
        {11'h400, 11'h7FF, 11'h400},
        {11'h03F, 11'h0F0, 11'h030},
        {11'h000, 11'h7FF, 11'h000},
        {11'h5AA, 11'h3CF, 11'h18A}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] irq_lines = '0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        msg_valid, msg_ready = 1'b0;
    logic [31:0] msg_addr, msg_data;

    int total = 0, bad = 0, msgs = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    msi_irq_concentrator i_msi_irq_concentrator (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    // Count handshakes: a valid+ready seen at a falling edge completes next edge.
    always @(negedge clk) if (rst_n && msg_valid && msg_ready) msgs++;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_rd = 1'b1; cfg_addr = a;
        @(negedge clk);
        cfg_rd = 1'b0;
        d = cfg_rdata;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        int m0;
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        check("R1 valid", {31'b0, msg_valid}, 32'h0);
        reg_read(A_TGT, d); check("R1 target", d, 32'h0);
        reg_read(A_PA, d);  check("R1 pend_a", d, 32'h0);
        reg_read(A_MSK, d); check("R1 mask", d, 32'h0);
        reg_read(A_PB, d);  check("R1 pend_b", d, 32'h0);
        reg_read(A_LVL, d); check("R1 level", d, 32'h0);

        // R9: events before the target word is written raise no message
        reg_write(A_MSK, 32'h7FF);
        irq_lines = 11'h001;
        idle(6);
        check("R9 no msg unarmed", {31'b0, msg_valid}, 32'h0);
        reg_read(A_PB, d); check("R2 pend bit0", d, 32'h001);
        irq_lines = '0;
        idle(4);

        // R12: readback of mask and target word
        reg_write(A_TGT, 32'h8000_1234);
        reg_read(A_TGT, d); check("R12 target", d, 32'h8000_1234);
        reg_write(A_MSK, 32'hFFFF_FFFF);
        reg_read(A_MSK, d); check("R12 mask", d, 32'h0000_07FF);

        // R10 and R7: latency and message contents
        msg_ready = 1'b0;
        @(negedge clk); irq_lines[2] = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R10 not at k", {31'b0, msg_valid}, 32'h0);
        @(posedge clk); @(negedge clk);
        check("R10 not at k+1", {31'b0, msg_valid}, 32'h0);
        @(posedge clk); @(negedge clk);
        check("R10 at k+2", {31'b0, msg_valid}, 32'h1);
        check("R7 addr", msg_addr, 32'h8000_1220);
        check("R7 data", msg_data, 32'h0000_0014);

        // R8: hold while stalled and merge a later event
        irq_lines[3] = 1'b1;
        idle(5);
        check("R8 still valid", {31'b0, msg_valid}, 32'h1);
        check("R8 addr held", msg_addr, 32'h8000_1220);
        m0 = msgs;
        msg_ready = 1'b1;
        idle(6);
        check("R8 one transfer", msgs - m0, 1);
        check("R8 no duplicate", {31'b0, msg_valid}, 32'h0);
        reg_read(A_PB, d); check("R2 merged pending", d, 32'h00C);
        irq_lines = '0;
        idle(4);

        // R3: masked edge and already-high line on unmask
        reg_write(A_MSK, 32'h0);
        reg_read(A_PB, d);
        m0 = msgs;
        irq_lines[4] = 1'b1;
        idle(5);
        reg_write(A_MSK, 32'h010);
        idle(5);
        reg_read(A_PB, d); check("R3 no pending", d, 32'h0);
        check("R3 no message", msgs - m0, 0);

        // R6: level reflects masked lines
        reg_write(A_MSK, 32'h0);
        irq_lines = 11'h505;
        idle(4);
        reg_read(A_LVL, d); check("R6 level", d, 32'h505);
        irq_lines = '0;
        idle(4);

        // R4 and R5: subset clear, bit 9 retained for the secondary view
        reg_write(A_MSK, 32'h201);
        irq_lines = 11'h201;
        idle(5);
        reg_read(A_PA, d); check("R4 pend_a value", d, 32'h001);
        reg_read(A_PA, d); check("R4 pend_a cleared", d, 32'h0);
        reg_read(A_PB, d); check("R4 bit9 kept", d, 32'h200);
        reg_read(A_PB, d); check("R5 pend_b cleared", d, 32'h0);
        reg_read(A_LVL, d); check("R5 level unchanged", d, 32'h201);
        irq_lines = '0;
        idle(4);

        // R11: capture coinciding with a clearing read
        reg_write(A_MSK, 32'h002);
        reg_read(A_PB, d);
        @(negedge clk); irq_lines[1] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); cfg_rd = 1'b1; cfg_addr = A_PB;
        @(posedge clk); @(negedge clk); cfg_rd = 1'b0;
        check("R11 read before edge", cfg_rdata, 32'h0);
        reg_read(A_PB, d); check("R11 bit survives", d, 32'h002);
        irq_lines = '0;
        idle(4);

        // R2: table of mask and line patterns
        for (int i = 0; i < 6; i++) begin
            reg_write(A_MSK, {21'b0, VEC[i][32:22]});
            reg_read(A_PB, d);
            irq_lines = VEC[i][21:11];
            idle(5);
            reg_read(A_PB, d);
            check($sformatf("R2 vector %0d", i), d, {21'b0, VEC[i][10:0]});
            irq_lines = '0;
            idle(4);
            reg_read(A_PB, d);
            check($sformatf("R2 falling vector %0d", i), d, 32'h0);
        end

        done = 1'b1;
        finish_run();
    end
endmodule